// File: doc/BRIEF.md
# Masked-Bit Address Concentrator

This combinational block sits behind a ternary remap lookup. It takes an address of `LANES` bits and a mask of the same width. Each set mask bit marks a don't-care position of the matching remap entry. The block gathers the address bits found at the masked positions into a dense sub-address, which then indexes a spare cube of storage.

Each lane carries a pair made of an address bit and a key bit, where the key is the mask bit. The block is built only from two-lane compare-swap cells. Each cell moves a keyed lane toward the low outputs and never separates an address bit from its key.

Two networks are built side by side, and `keep_order` picks which one drives the outputs:
- The ordered network uses adjacent swaps only. It keeps the selected bits in their original relative order.
- The bijective network is a shallower sorter. It packs the selected bits into the low lanes in an order that may be permuted, but that order is fixed for a given mask.

The lowest `SUB_W` output lanes form the sub-address.

Top module: `mbit_concentrator`

## Requirements
- R1: An output lane whose key is 0 carries data 0, in both modes, for any address and mask.
- R2: In both modes, the number of output lanes with key 1 equals the number of set mask bits. Those lanes are exactly the lowest ones, so `lane_key_out` equals 2^k - 1 when k mask bits are set.
- R3: With `keep_order` = 1, output lane i carries the address bit at the i-th lowest set mask position.
- R4: With `keep_order` = 0 and at most `SUB_W` mask bits set, two addresses that differ in at least one masked bit produce different `sub_addr` values under the same mask.
- R5: `sub_addr` bit i equals `lane_data_out` bit i, for i from 0 to `SUB_W`-1.
- R6: With 8 lanes, mask 8'hAA (positions 1, 3, 5, 7) and `keep_order` = 1, output lanes 0 to 3 carry address bits 1, 3, 5 and 7 with key 1. Lanes 4 to 7 carry data 0 and key 0.
- R7: An all-zero mask gives all-zero `lane_data_out`, `lane_key_out` and `sub_addr` in both modes. An all-ones mask with `keep_order` = 1 reproduces the address unchanged.
- R8: With `keep_order` = 0, the number of ones in `lane_data_out` equals the number of ones in the address bits at masked positions.
- R9: Address bits at positions whose mask bit is 0 have no effect on any output in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_in | input | LANES | Address to be concentrated |
| mask_in | input | LANES | Don't-care positions from the matching remap entry; 1 = extract this bit |
| keep_order | input | 1 | 1 selects the order-preserving network, 0 the bijective network |
| lane_data_out | output | LANES | Compacted address bits, selected bits in the low lanes |
| lane_key_out | output | LANES | Key of each output lane, 1 for lanes carrying an extracted bit |
| sub_addr | output | SUB_W | Spare-cube index taken from the lowest output lanes |

## Verification
The ordered network is driven with sparse random masks of up to `SUB_W` set bits and compared against a plain bit-gather. This separates a correct stable compaction from one that drops, duplicates or reorders bits. The fixed alternating mask and the empty and full masks pin down the exact lane placement and the fill of unused lanes.

The bijective network cannot be compared with a fixed order. For each of several masks, it is swept over every combination of the masked bits, and the resulting sub-addresses must all differ; this exposes any collision. Separate sweeps vary only the unmasked bits and require that the outputs stay put. This catches unselected data leaking into the lanes.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  // Depth of an odd-even transposition network: one stage per lane.
  function automatic int oet_depth(input int lanes);
    return lanes;
  endfunction

  // Depth of a full bitonic network over 2**lg lanes.
  function automatic int bitonic_depth(input int lg);
    return lg * (lg + 1) / 2;
  endfunction

endpackage

// File: rtl/mbc_swap.sv
module mbc_swap #(
  parameter bit LOW_FIRST = 1'b1
) (
  input  logic lo_d,
  input  logic lo_k,
  input  logic hi_d,
  input  logic hi_k,
  output logic lo_d_o,
  output logic lo_k_o,
  output logic hi_d_o,
  output logic hi_k_o
);
  logic xchg;

  always_comb begin
    if (LOW_FIRST) xchg = !lo_k && hi_k;
    else           xchg = lo_k && !hi_k;
    lo_d_o = xchg ? hi_d : lo_d;
    lo_k_o = xchg ? hi_k : lo_k;
    hi_d_o = xchg ? lo_d : hi_d;
    hi_k_o = xchg ? lo_k : hi_k;
  end
endmodule

// File: rtl/mbc_ordered_net.sv
module mbc_ordered_net
  import mbc_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0] d_in,
  input  logic [LANES-1:0] k_in,
  output logic [LANES-1:0] d_out,
  output logic [LANES-1:0] k_out
);
  localparam int DEPTH = oet_depth(LANES);

  logic [LANES-1:0] d_st [0:DEPTH];
  logic [LANES-1:0] k_st [0:DEPTH];

  assign d_st[0] = d_in;
  assign k_st[0] = k_in;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    for (genvar i = s % 2; i + 1 < LANES; i += 2) begin : g_pair
      mbc_swap #(.LOW_FIRST(1'b1)) u_swap (
        .lo_d  (d_st[s][i]),   .lo_k  (k_st[s][i]),
        .hi_d  (d_st[s][i+1]), .hi_k  (k_st[s][i+1]),
        .lo_d_o(d_st[s+1][i]), .lo_k_o(k_st[s+1][i]),
        .hi_d_o(d_st[s+1][i+1]), .hi_k_o(k_st[s+1][i+1])
      );
    end
    if (s % 2 == 1) begin : g_edge
      assign d_st[s+1][0]       = d_st[s][0];
      assign k_st[s+1][0]       = k_st[s][0];
      assign d_st[s+1][LANES-1] = d_st[s][LANES-1];
      assign k_st[s+1][LANES-1] = k_st[s][LANES-1];
    end
  end

  assign d_out = d_st[DEPTH];
  assign k_out = k_st[DEPTH];
endmodule

// File: rtl/mbc_bijective_net.sv
module mbc_bijective_net
  import mbc_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0] d_in,
  input  logic [LANES-1:0] k_in,
  output logic [LANES-1:0] d_out,
  output logic [LANES-1:0] k_out
);
  localparam int LG    = $clog2(LANES);
  localparam int DEPTH = bitonic_depth(LG);

  logic [LANES-1:0] d_st [0:DEPTH];
  logic [LANES-1:0] k_st [0:DEPTH];

  assign d_st[0] = d_in;
  assign k_st[0] = k_in;

  for (genvar p = 1; p <= LG; p++) begin : g_merge
    for (genvar q = p - 1; q >= 0; q--) begin : g_step
      localparam int ST = p * (p - 1) / 2 + (p - 1 - q);
      for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (((i >> q) & 1) == 0) begin : g_cell
          mbc_swap #(.LOW_FIRST(((i >> p) & 1) == 0)) u_swap (
            .lo_d  (d_st[ST][i]),          .lo_k  (k_st[ST][i]),
            .hi_d  (d_st[ST][i+(1<<q)]),   .hi_k  (k_st[ST][i+(1<<q)]),
            .lo_d_o(d_st[ST+1][i]),        .lo_k_o(k_st[ST+1][i]),
            .hi_d_o(d_st[ST+1][i+(1<<q)]), .hi_k_o(k_st[ST+1][i+(1<<q)])
          );
        end
      end
    end
  end

  assign d_out = d_st[DEPTH];
  assign k_out = k_st[DEPTH];
endmodule

// File: rtl/mbit_concentrator.sv
module mbit_concentrator #(
  parameter int LANES = 8,
  parameter int SUB_W = 4
) (
  input  logic [LANES-1:0] addr_in,
  input  logic [LANES-1:0] mask_in,
  input  logic             keep_order,
  output logic [LANES-1:0] lane_data_out,
  output logic [LANES-1:0] lane_key_out,
  output logic [SUB_W-1:0] sub_addr
);
  logic [LANES-1:0] gated_d;
  logic [LANES-1:0] ord_d, ord_k, bij_d, bij_k;

  // Unselected lanes enter the networks as (0, 0).
  assign gated_d = addr_in & mask_in;

  mbc_ordered_net #(.LANES(LANES)) u_ordered (
    .d_in (gated_d), .k_in (mask_in),
    .d_out(ord_d),   .k_out(ord_k)
  );

  mbc_bijective_net #(.LANES(LANES)) u_bijective (
    .d_in (gated_d), .k_in (mask_in),
    .d_out(bij_d),   .k_out(bij_k)
  );

  always_comb begin
    lane_data_out = keep_order ? ord_d : bij_d;
    lane_key_out  = keep_order ? ord_k : bij_k;
  end

  assign sub_addr = lane_data_out[SUB_W-1:0];
endmodule

// File: rtl/mbit_concentrator_chk.sv
module mbit_concentrator_chk #(
  parameter int LANES = 8,
  parameter int SUB_W = 4
) (
  input logic [LANES-1:0] addr_in,
  input logic [LANES-1:0] mask_in,
  input logic             keep_order,
  input logic [LANES-1:0] lane_data_out,
  input logic [LANES-1:0] lane_key_out,
  input logic [SUB_W-1:0] sub_addr
);
  logic [LANES:0] therm;

  always_comb begin
    therm = (({{LANES{1'b0}}, 1'b1}) << $countones(mask_in)) - 1'b1;
    assert_idle_lanes_zero_R1: assert ((lane_data_out & ~lane_key_out) == '0);
    assert_key_count_R2: assert ($countones(lane_key_out) == $countones(mask_in));
    assert_keys_packed_low_R2: assert ({1'b0, lane_key_out} == therm);
    assert_sub_from_low_lanes_R5: assert (sub_addr == lane_data_out[SUB_W-1:0]);
    if (!keep_order) begin
      assert_ones_kept_R8: assert ($countones(lane_data_out) == $countones(addr_in & mask_in));
    end
  end
endmodule

bind mbit_concentrator mbit_concentrator_chk #(.LANES(LANES), .SUB_W(SUB_W)) i_chk (
  .addr_in(addr_in), .mask_in(mask_in), .keep_order(keep_order),
  .lane_data_out(lane_data_out), .lane_key_out(lane_key_out), .sub_addr(sub_addr)
);

// File: tb/test_mbit_concentrator.sv
module test_mbit_concentrator;
  localparam int LANES = 8;
  localparam int SUB_W = 4;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LANES-1:0] addr_in = '0, mask_in = '0;
  logic keep_order = 1'b1;
  logic [LANES-1:0] lane_data_out, lane_key_out;
  logic [SUB_W-1:0] sub_addr;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  mbit_concentrator #(.LANES(LANES), .SUB_W(SUB_W)) i_mbit_concentrator (
    .addr_in(addr_in), .mask_in(mask_in), .keep_order(keep_order),
    .lane_data_out(lane_data_out), .lane_key_out(lane_key_out), .sub_addr(sub_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (mask=%h addr=%h order=%0b)",
               req, act, exp, mask_in, addr_in, keep_order);
    end
  endtask

  function automatic logic [LANES-1:0] gather(input logic [LANES-1:0] a, input logic [LANES-1:0] m);
    logic [LANES-1:0] r = '0;
    int n = 0;
    for (int i = 0; i < LANES; i++) if (m[i]) begin r[n] = a[i]; n++; end
    return r;
  endfunction

  function automatic logic [LANES-1:0] sparse_mask();
    logic [LANES-1:0] m = '0;
    int cnt = $urandom_range(SUB_W, 0);
    for (int i = 0; i < cnt; i++) m[$urandom_range(LANES-1, 0)] = 1'b1;
    return m;
  endfunction

  task automatic apply(input logic [LANES-1:0] a, input logic [LANES-1:0] m, input logic o);
    @(negedge clk);
    addr_in = a; mask_in = m; keep_order = o;
    #1;
  endtask

  task automatic t_empty_and_full();
    for (int o = 0; o < 2; o++) begin
      apply(8'h5C, '0, o[0]);
      check("R7 empty data", lane_data_out, 0);
      check("R7 empty key", lane_key_out, 0);
      check("R7 empty sub", sub_addr, 0);
    end
    apply(8'hB6, '1, 1'b1);
    check("R7 full data", lane_data_out, 8'hB6);
    check("R2 full key", lane_key_out, 8'hFF);
  endtask

  task automatic t_alternating();
    // bits 1,3,5,7 = a,b,c,d = 1,0,1,1
    apply(8'b1010_0010, 8'hAA, 1'b1);
    check("R6 data", lane_data_out, 8'b0000_1101);
    check("R6 key", lane_key_out, 8'h0F);
    check("R5 sub", sub_addr, 4'b1101);
    apply(8'b0101_1111, 8'hAA, 1'b1);
    check("R6 data low zero", lane_data_out, 8'b0000_0011);
  endtask

  task automatic t_ordered_random();
    for (int t = 0; t < 200; t++) begin
      logic [LANES-1:0] m = sparse_mask();
      logic [LANES-1:0] a = LANES'($urandom);
      apply(a, m, 1'b1);
      check("R3 gather", lane_data_out, gather(a, m));
      check("R2 packed keys", lane_key_out, (1 << $countones(m)) - 1);
      check("R1 idle lanes", lane_data_out & ~lane_key_out, 0);
      check("R5 sub", sub_addr, gather(a, m) & 4'hF);
    end
  endtask

  task automatic t_bijective_random();
    for (int t = 0; t < 200; t++) begin
      logic [LANES-1:0] m = LANES'($urandom);
      logic [LANES-1:0] a = LANES'($urandom);
      apply(a, m, 1'b0);
      check("R2 packed keys", lane_key_out, (1 << $countones(m)) - 1);
      check("R8 ones count", $countones(lane_data_out), $countones(a & m));
      check("R1 idle lanes", lane_data_out & ~lane_key_out, 0);
    end
  endtask

  task automatic t_bijective_injective();
    for (int t = 0; t < 30; t++) begin
      logic [LANES-1:0] m = (t == 0) ? 8'hF0 : sparse_mask();
      int k = $countones(m);
      bit [15:0] seen = '0;
      int coll = 0;
      for (int v = 0; v < (1 << k); v++) begin
        logic [LANES-1:0] a = LANES'($urandom) & ~m;
        int n = 0;
        for (int i = 0; i < LANES; i++) if (m[i]) begin a[i] = v[n]; n++; end
        apply(a, m, 1'b0);
        if (seen[sub_addr]) coll++;
        seen[sub_addr] = 1'b1;
      end
      check("R4 collisions", coll, 0);
    end
  endtask

  task automatic t_unmasked_ignored();
    for (int o = 0; o < 2; o++) begin
      for (int t = 0; t < 40; t++) begin
        logic [LANES-1:0] m = LANES'($urandom);
        logic [LANES-1:0] a = LANES'($urandom);
        logic [LANES-1:0] d0, k0;
        apply(a, m, o[0]);
        d0 = lane_data_out; k0 = lane_key_out;
        apply(a ^ (LANES'($urandom) & ~m), m, o[0]);
        check("R9 data unchanged", lane_data_out, d0);
        check("R9 key unchanged", lane_key_out, k0);
      end
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_empty_and_full();
    t_alternating();
    t_ordered_random();
    t_bijective_random();
    t_bijective_injective();
    t_unmasked_ignored();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule